// File: doc/BRIEF.md
# Bidirectional GPIO Port with Level Alarms

This block is a general-purpose I/O port of configurable width. Each bit may be an input or an output, chosen on its own. A single command channel drives it: a valid strobe, a 4-bit opcode and a word of argument bits. Every command takes effect at the clock edge where the strobe is sampled. The response word appears one cycle later, flagged by a response strobe.

The pad is modelled as three vectors: the driven value, the output enable and the sampled pin value. Pin values pass through a synchroniser before any read or alarm logic uses them. Each bit can be armed to raise an alarm while its synchronised pin is high, while it is low, or both. The OR of all active alarms forms a level-sensitive interrupt.

Top module: `gpio_alarm_port`

## Requirements
- R1: After reset, pad_oe, pad_out, irq and rsp_valid are all 0, and no alarm is armed.
- R2: Opcode 1 (drive-high) sets every output shadow bit whose argument bit is 1 and leaves all other shadow bits unchanged.
- R3: Opcode 2 (drive-low) clears every output shadow bit whose argument bit is 1 and leaves all other shadow bits unchanged.
- R4: Opcode 6 (make-input) makes each marked bit an input, and opcode 7 (make-output) makes each marked bit an output. Unmarked bits keep their direction. Direction 1 means output. Opcode 6 responds with the mask of bits that are inputs after the command, and opcode 7 responds with the mask of bits that are outputs after it.
- R5: pad_oe always equals the direction register and pad_out always equals the output shadow. The shadow keeps its value while a bit is an input.
- R6: Opcode 8 returns the pin values after a two-stage synchroniser. A pin change is visible to reads and alarms two clock edges after it is sampled.
- R7: Opcode 9 returns the output shadow, not the pin values.
- R8: Opcode 3 arms a high-level alarm and opcode 4 arms a low-level alarm on each marked bit. irq is 1 while any bit armed for high has a synchronised pin of 1, or any bit armed for low has a synchronised pin of 0.
- R9: Opcode 5 disarms both alarm types on each marked bit and leaves the alarms of unmarked bits armed.
- R10: irq is level-sensitive. It falls once no armed bit sits at its armed level, with the same two-edge latency from the pin.
- R11: rsp_valid is 1 exactly one cycle after an accepted command. Opcodes 1 to 5 respond with zero.
- R12: Opcodes 0 and 10 to 15 change no state and respond with zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_arg | input | WIDTH | Argument bit mask |
| rsp_valid | output | 1 | Response strobe, one cycle after a command |
| rsp_data | output | WIDTH | Response word |
| pad_in | input | WIDTH | Pin values from the pad |
| pad_out | output | WIDTH | Value driven to the pad |
| pad_oe | output | WIDTH | Pad output enable, 1 = output |
| irq | output | 1 | Level alarm interrupt |

## Verification
A corrupted shadow or direction bit is visible on pad_out or pad_oe at the very next cycle. It also shows in the make-input, make-output and read-shadow responses, so every direction and drive test compares both the pad vectors and the response word. A wrong alarm arm bit shows only when its pin sits at the armed level. For that reason the bench drives each armed pin to both levels and checks irq at both one and two edges after the change. This proves both the synchroniser depth and the armed state. Disarm tests then sweep the pin to show that the disarmed bit stays silent, while another bit that is still armed keeps irq working.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_DRV_HI   = 4'd1,
    OP_DRV_LO   = 4'd2,
    OP_ARM_HI   = 4'd3,
    OP_ARM_LO   = 4'd4,
    OP_DISARM   = 4'd5,
    OP_MAKE_IN  = 4'd6,
    OP_MAKE_OUT = 4'd7,
    OP_RD_PINS  = 4'd8,
    OP_RD_SHAD  = 4'd9
  } gpio_op_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_hi_en,
  input  logic             drv_lo_en,
  input  logic             make_in_en,
  input  logic             make_out_en,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] shadow,
  output logic [WIDTH-1:0] dir,
  output logic [WIDTH-1:0] dir_nxt
);
  logic [WIDTH-1:0] shadow_nxt;

  function automatic logic [WIDTH-1:0] bits_set(input logic [WIDTH-1:0] cur,
                                                input logic [WIDTH-1:0] m);
    return cur | m;
  endfunction

  function automatic logic [WIDTH-1:0] bits_clr(input logic [WIDTH-1:0] cur,
                                                input logic [WIDTH-1:0] m);
    return cur & ~m;
  endfunction

  always_comb begin
    shadow_nxt = shadow;
    if (drv_hi_en)      shadow_nxt = bits_set(shadow, mask);
    else if (drv_lo_en) shadow_nxt = bits_clr(shadow, mask);
    dir_nxt = dir;
    if (make_out_en)     dir_nxt = bits_set(dir, mask);
    else if (make_in_en) dir_nxt = bits_clr(dir, mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      dir    <= '0;
    end else begin
      shadow <= shadow_nxt;
      dir    <= dir_nxt;
    end
  end

  // R2
  drive_hi_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_hi_en |=> ((shadow & $past(mask)) == $past(mask)));
  // R2
  drive_hi_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_hi_en |=> ((shadow & ~$past(mask)) == ($past(shadow) & ~$past(mask))));
  // R3
  drive_lo_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_lo_en |=> ((shadow & $past(mask)) == '0));
  // R4
  make_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    make_out_en |=> ((dir & $past(mask)) == $past(mask)));
  // R4
  make_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    make_in_en |=> ((dir & $past(mask)) == '0));
  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi_en || drv_lo_en) |=> $stable(shadow));
endmodule

// File: rtl/gpio_alarm_unit.sv
module gpio_alarm_unit #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_hi_en,
  input  logic             arm_lo_en,
  input  logic             disarm_en,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] hi_armed,
  output logic [WIDTH-1:0] lo_armed,
  output logic             irq
);
  logic [WIDTH-1:0] hit_vec;

  function automatic logic [WIDTH-1:0] alarm_hits(input logic [WIDTH-1:0] hi,
                                                  input logic [WIDTH-1:0] lo,
                                                  input logic [WIDTH-1:0] lvl);
    return (hi & lvl) | (lo & ~lvl);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_armed <= '0;
      lo_armed <= '0;
    end else if (disarm_en) begin
      hi_armed <= hi_armed & ~mask;
      lo_armed <= lo_armed & ~mask;
    end else begin
      if (arm_hi_en) hi_armed <= hi_armed | mask;
      if (arm_lo_en) lo_armed <= lo_armed | mask;
    end
  end

  assign hit_vec = alarm_hits(hi_armed, lo_armed, level);
  assign irq     = |hit_vec;

  // R9
  disarm_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_en |=> (((hi_armed | lo_armed) & $past(mask)) == '0));
  // R9
  disarm_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_en |=> ((hi_armed & ~$past(mask)) == ($past(hi_armed) & ~$past(mask))));
  // R8
  arm_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_hi_en |=> ((hi_armed & $past(mask)) == $past(mask)));
  // R10
  no_arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_armed | lo_armed) == '0) |-> !irq);
endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port
  import gpio_alarm_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [WIDTH-1:0] cmd_arg,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic             irq
);
  gpio_op_e         op;
  logic             drv_hi_en, drv_lo_en, make_in_en, make_out_en;
  logic             arm_hi_en, arm_lo_en, disarm_en, rd_pins_en, rd_shad_en;
  logic [WIDTH-1:0] pins_sync, shadow, dir, dir_nxt, hi_armed, lo_armed;
  logic [WIDTH-1:0] rsp_nxt;

  assign op          = gpio_op_e'(cmd_op);
  assign drv_hi_en   = cmd_valid && (op == OP_DRV_HI);
  assign drv_lo_en   = cmd_valid && (op == OP_DRV_LO);
  assign make_in_en  = cmd_valid && (op == OP_MAKE_IN);
  assign make_out_en = cmd_valid && (op == OP_MAKE_OUT);
  assign arm_hi_en   = cmd_valid && (op == OP_ARM_HI);
  assign arm_lo_en   = cmd_valid && (op == OP_ARM_LO);
  assign disarm_en   = cmd_valid && (op == OP_DISARM);
  assign rd_pins_en  = cmd_valid && (op == OP_RD_PINS);
  assign rd_shad_en  = cmd_valid && (op == OP_RD_SHAD);

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .drv_hi_en(drv_hi_en), .drv_lo_en(drv_lo_en),
    .make_in_en(make_in_en), .make_out_en(make_out_en),
    .mask(cmd_arg), .shadow(shadow), .dir(dir), .dir_nxt(dir_nxt)
  );

  gpio_alarm_unit #(.WIDTH(WIDTH)) alarm_i (
    .clk(clk), .rst_n(rst_n),
    .arm_hi_en(arm_hi_en), .arm_lo_en(arm_lo_en), .disarm_en(disarm_en),
    .mask(cmd_arg), .level(pins_sync),
    .hi_armed(hi_armed), .lo_armed(lo_armed), .irq(irq)
  );

  always_comb begin
    rsp_nxt = '0;
    if (make_in_en)       rsp_nxt = ~dir_nxt;
    else if (make_out_en) rsp_nxt = dir_nxt;
    else if (rd_pins_en)  rsp_nxt = pins_sync;
    else if (rd_shad_en)  rsp_nxt = shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) rsp_data <= rsp_nxt;
    end
  end

  assign pad_out = shadow;
  assign pad_oe  = dir;

  // R11
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  // R11
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  // R7
  rd_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_shad_en |=> (rsp_data == pad_out));
  // R4
  make_out_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    make_out_en |=> (rsp_data == pad_oe));
endmodule

// File: tb/gpio_alarm_port_tb.sv
module gpio_alarm_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [3:0]   cmd_op = 4'd0;
  logic [W-1:0] cmd_arg = '0;
  logic         rsp_valid;
  logic [W-1:0] rsp_data;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  gpio_alarm_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one command; returns after the response cycle (sampled at negedge)
  task automatic issue(input logic [3:0] op, input logic [W-1:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0; cmd_arg = '0;
  endtask

  task automatic pins(input logic [W-1:0] v, input int edges);
    @(negedge clk);
    pad_in = v;
    repeat (edges) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 pad_oe", pad_oe, 0);
    check("R1 pad_out", pad_out, 0);
    check("R1 irq", irq, 0);
    check("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_drive();
    issue(4'd1, 8'hA5);
    check("R2 set", pad_out, 8'hA5);
    check("R11 rsp_valid", rsp_valid, 1);
    check("R11 zero rsp", rsp_data, 0);
    issue(4'd1, 8'h0F);
    check("R2 set keeps others", pad_out, 8'hAF);
    issue(4'd2, 8'h81);
    check("R3 clear", pad_out, 8'h2E);
    @(negedge clk);
    check("R11 rsp_valid drops", rsp_valid, 0);
  endtask

  task automatic t_dir();
    issue(4'd7, 8'hF0);
    check("R4 out rsp", rsp_data, 8'hF0);
    check("R5 pad_oe", pad_oe, 8'hF0);
    issue(4'd7, 8'h03);
    check("R4 out merge", rsp_data, 8'hF3);
    issue(4'd6, 8'h30);
    check("R4 in rsp", rsp_data, 8'h3C);
    check("R5 pad_oe after in", pad_oe, 8'hC3);
    check("R5 shadow kept", pad_out, 8'h2E);
  endtask

  task automatic t_reads();
    pins(8'h5A, 2);
    issue(4'd8, 8'h00);
    check("R6 read pins", rsp_data, 8'h5A);
    issue(4'd9, 8'h00);
    check("R7 read shadow", rsp_data, 8'h2E);
    pins(8'h33, 1);
    issue(4'd8, 8'h00);
    check("R6 sync depth", rsp_data, 8'h33);
  endtask

  task automatic t_alarms();
    pins(8'h00, 2);
    issue(4'd3, 8'h01);
    check("R8 hi armed, pin low", irq, 0);
    pins(8'h01, 1);
    check("R6 irq latency 1", irq, 0);
    @(negedge clk);
    check("R8 hi alarm", irq, 1);
    pins(8'h00, 2);
    check("R10 level drop", irq, 0);
    issue(4'd4, 8'h08);
    check("R8 lo alarm", irq, 1);
    issue(4'd5, 8'h08);
    check("R9 disarm lo", irq, 0);
    pins(8'h01, 2);
    check("R9 hi kept", irq, 1);
    issue(4'd5, 8'h01);
    check("R9 disarm hi", irq, 0);
    issue(4'd3, 8'h02);
    issue(4'd4, 8'h02);
    check("R8 both armed", irq, 1);
    issue(4'd5, 8'h02);
    pins(8'h00, 2);
    check("R9 both cleared low", irq, 0);
    pins(8'h02, 2);
    check("R9 both cleared high", irq, 0);
  endtask

  task automatic t_unused();
    issue(4'd0, 8'hFF);
    check("R12 nop rsp", rsp_data, 0);
    issue(4'd12, 8'hFF);
    check("R12 unused rsp", rsp_data, 0);
    check("R12 shadow", pad_out, 8'h2E);
    check("R12 dir", pad_oe, 8'hC3);
    pins(8'hFF, 2);
    check("R12 no alarm armed", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_drive();
    t_dir();
    t_reads();
    t_alarms();
    t_unused();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule